// File: doc/BRIEF.md
# Exception entry controller

This block performs the architectural state update a processor core makes when it takes a general exception or a debug exception. It holds the status word, the exception program counters, the double-exception program counter, the per-level saved status words, the cause registers and the fault address register. In the cycle after a request it commits every update at once and reports the vector the core must fetch from: user, kernel, double or debug.

A general request carries a cause code, the current program counter and, for address-related faults, a faulting virtual address. Whether the exception-mode bit is already set decides between the first-level and the double-exception path. Whether a dedicated double-exception PC register exists is a build parameter. A debug request carries a debug cause and the configured debug level. It is taken only when the current interrupt level is below that level. When taken, it saves the PC and the old status word in registers indexed by that level, then raises the interrupt level to it. The core loads the status word through a plain load port, for example on a return from an exception.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous reset clears the status word, every program counter register, every saved status word, both cause registers and the fault address to zero, and `vec_valid_o` is low.
- R2: A general exception taken while the EXCM bit (status bit 4) is clear writes `cur_pc` into EPC level 1 (`epc_o[0]`). It selects the user vector (code 0) when the UM bit (status bit 5) is set and the kernel vector (code 1) when UM is clear.
- R3: A general exception taken while EXCM is set, in a build with the double-exception PC register (`HAS_DEPC`=1), writes `cur_pc` into `depc_o`, leaves `epc_o[0]` unchanged and selects the double vector (code 2).
- R4: In a build without that register (`HAS_DEPC`=0), a general exception taken while EXCM is set writes `cur_pc` into `epc_o[0]` and still selects the double vector (code 2).
- R5: Every general exception taken writes `exc_cause` into `excause_o` and sets EXCM. All other status bits keep their values.
- R6: A general exception with `exc_has_addr` high writes `exc_vaddr` into `excvaddr_o`. With `exc_has_addr` low, `excvaddr_o` is unchanged.
- R7: A debug request is taken only when `dbg_level` lies in 2..NLEVELS and the status INTLEVEL field (bits 3:0) is below `dbg_level`. Otherwise the request changes no register and produces no vector pulse.
- R8: A debug exception taken writes `dbg_cause` into `dbgcause_o`, `cur_pc` into `epc_o[dbg_level-1]` and the old status word into `eps_o[dbg_level-2]`. It sets EXCM, sets INTLEVEL to `dbg_level`, keeps UM and selects the debug vector (code 3).
- R9: All updates for one exception commit at the first clock edge after the request. `vec_valid_o` is high for exactly the cycle following each taken request, so consecutive requests give consecutive pulses.
- R10: When a debug request is taken in the same cycle as a general request, only the debug exception is taken. The general request has no effect on `excause_o`, `excvaddr_o` or `depc_o`.
- R11: `ps_load` writes `ps_load_val` into the status word at the next edge, but only in a cycle in which no exception is taken. An exception taken in that cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_has_addr | input | 1 | Request carries a faulting address |
| exc_vaddr | input | XLEN | Faulting virtual address |
| cur_pc | input | XLEN | Program counter of the excepting instruction |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| dbg_level | input | 4 | Configured debug interrupt level |
| ps_load | input | 1 | Load the status word |
| ps_load_val | input | 8 | Status word value to load |
| ps_o | output | 8 | Status word (INTLEVEL 3:0, EXCM 4, UM 5) |
| epc_o | output | NLEVELS x XLEN | Exception PC per level, entry i is level i+1 |
| depc_o | output | XLEN | Double-exception PC |
| eps_o | output | (NLEVELS-1) x 8 | Saved status per level, entry i is level i+2 |
| excause_o | output | CAUSE_W | General exception cause |
| excvaddr_o | output | XLEN | Faulting virtual address |
| dbgcause_o | output | DCAUSE_W | Debug cause |
| vec_valid_o | output | 1 | One-cycle pulse marking a taken exception |
| vec_o | output | 2 | Selected vector: 0 user, 1 kernel, 2 double, 3 debug |

## Verification
General requests are applied with EXCM clear under both UM values, which separates the user and kernel vectors. They are also applied with EXCM set, to two builds that differ only in the double-exception register. This shows which save register each build picks while both report the double vector. Debug requests are swept across interrupt levels equal to the debug level, below it, and at the highest level, and with out-of-range debug levels. Together these separate taken from ignored requests and probe both ends of the level-indexed registers. Requests that collide in the same cycle (debug with general, status load with general) and back-to-back requests expose the priority order and the per-cycle pulse.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int PS_W     = 8;
    localparam int IL_W     = 4;
    localparam int IL_LSB   = 0;
    localparam int EXCM_BIT = 4;
    localparam int UM_BIT   = 5;

    typedef enum logic [1:0] {
        VEC_USER   = 2'd0,
        VEC_KERNEL = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } vec_e;
endpackage

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate #(
    parameter int IL_W    = 4,
    parameter int NLEVELS = 7
) (
    input  logic            req,
    input  logic [IL_W-1:0] cur_il,
    input  logic [IL_W-1:0] level,
    output logic            take
);
    logic level_ok;

    always_comb begin
        level_ok = (level >= IL_W'(2)) && (level <= IL_W'(NLEVELS));
        take     = req && level_ok && (cur_il < level);
    end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic excm,
    input  logic um,
    output vec_e vec,
    output logic to_depc
);
    generate
        if (HAS_DEPC) begin : g_depc
            assign to_depc = excm;
        end else begin : g_no_depc
            assign to_depc = 1'b0;
        end
    endgenerate

    always_comb begin
        if (excm)    vec = VEC_DOUBLE;
        else if (um) vec = VEC_USER;
        else         vec = VEC_KERNEL;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 6,
    parameter int DCAUSE_W = 6,
    parameter int NLEVELS  = 7,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                exc_req,
    input  logic [CAUSE_W-1:0]                  exc_cause,
    input  logic                                exc_has_addr,
    input  logic [XLEN-1:0]                     exc_vaddr,
    input  logic [XLEN-1:0]                     cur_pc,
    input  logic                                dbg_req,
    input  logic [DCAUSE_W-1:0]                 dbg_cause,
    input  logic [3:0]                          dbg_level,
    input  logic                                ps_load,
    input  logic [7:0]                          ps_load_val,
    output logic [7:0]                          ps_o,
    output logic [NLEVELS-1:0][XLEN-1:0]        epc_o,
    output logic [XLEN-1:0]                     depc_o,
    output logic [NLEVELS-2:0][7:0]             eps_o,
    output logic [CAUSE_W-1:0]                  excause_o,
    output logic [XLEN-1:0]                     excvaddr_o,
    output logic [DCAUSE_W-1:0]                 dbgcause_o,
    output logic                                vec_valid_o,
    output logic [1:0]                          vec_o
);
    localparam int NEPS = NLEVELS - 1;

    typedef struct packed {
        logic [PS_W-1:0]                ps;
        logic [NLEVELS-1:0][XLEN-1:0]   epc;
        logic [XLEN-1:0]                depc;
        logic [NEPS-1:0][PS_W-1:0]      eps;
        logic [CAUSE_W-1:0]             cause;
        logic [XLEN-1:0]                vaddr;
        logic [DCAUSE_W-1:0]            dcause;
        logic                           vld;
        vec_e                           vec;
    } state_t;

    state_t st_d, st_q;
    logic   dbg_take;
    logic   to_depc;
    vec_e   gen_vec;

    exc_dbg_gate #(.IL_W(IL_W), .NLEVELS(NLEVELS)) u_gate (
        .req    (dbg_req),
        .cur_il (st_q.ps[IL_LSB +: IL_W]),
        .level  (dbg_level),
        .take   (dbg_take)
    );

    exc_vec_sel #(.HAS_DEPC(HAS_DEPC)) u_vsel (
        .excm    (st_q.ps[EXCM_BIT]),
        .um      (st_q.ps[UM_BIT]),
        .vec     (gen_vec),
        .to_depc (to_depc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (dbg_take) begin
            st_d.dcause = dbg_cause;
            for (int i = 0; i < NLEVELS; i++) begin
                if (dbg_level == IL_W'(i + 1)) st_d.epc[i] = cur_pc;
            end
            for (int j = 0; j < NEPS; j++) begin
                if (dbg_level == IL_W'(j + 2)) st_d.eps[j] = st_q.ps;
            end
            st_d.ps[IL_LSB +: IL_W] = dbg_level;
            st_d.ps[EXCM_BIT]       = 1'b1;
            st_d.vld                = 1'b1;
            st_d.vec                = VEC_DEBUG;
        end else if (exc_req) begin
            if (exc_has_addr) st_d.vaddr = exc_vaddr;
            if (to_depc) st_d.depc   = cur_pc;
            else         st_d.epc[0] = cur_pc;
            st_d.cause        = exc_cause;
            st_d.ps[EXCM_BIT] = 1'b1;
            st_d.vld          = 1'b1;
            st_d.vec          = gen_vec;
        end else if (ps_load) begin
            st_d.ps = ps_load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ps_o        = st_q.ps;
    assign epc_o       = st_q.epc;
    assign depc_o      = st_q.depc;
    assign eps_o       = st_q.eps;
    assign excause_o   = st_q.cause;
    assign excvaddr_o  = st_q.vaddr;
    assign dbgcause_o  = st_q.dcause;
    assign vec_valid_o = st_q.vld;
    assign vec_o       = st_q.vec;

    // R9
    gen_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !rst) |=> vec_valid_o);

    // R5
    excm_set_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> ps_o[EXCM_BIT]);

    // R5
    cause_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !dbg_take && !rst) |=> excause_o == $past(exc_cause));

    // R2
    epc1_save_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !dbg_take && !rst && (!ps_o[EXCM_BIT] || !HAS_DEPC))
        |=> epc_o[0] == $past(cur_pc));

    // R3
    depc_save_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !dbg_take && !rst && ps_o[EXCM_BIT] && HAS_DEPC)
        |=> (depc_o == $past(cur_pc)) && (vec_o == VEC_DOUBLE));

    // R8
    dbg_level_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o && vec_o == VEC_DEBUG) |-> ps_o[IL_LSB +: IL_W] == $past(dbg_level));

    // R7
    dbg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !dbg_take && !exc_req && !ps_load && !rst)
        |=> !vec_valid_o && $stable(ps_o));
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    import exc_entry_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic            exc_req, exc_has_addr, dbg_req, ps_load;
    logic [5:0]      exc_cause, dbg_cause;
    logic [31:0]     exc_vaddr, cur_pc;
    logic [3:0]      dbg_level;
    logic [7:0]      ps_load_val;

    logic [7:0]       ps_o, nd_ps;
    logic [6:0][31:0] epc_o, nd_epc;
    logic [31:0]      depc_o, nd_depc;
    logic [5:0][7:0]  eps_o, nd_eps;
    logic [5:0]       excause_o, nd_cause, dbgcause_o, nd_dcause;
    logic [31:0]      excvaddr_o, nd_vaddr;
    logic             vec_valid_o, nd_vld;
    logic [1:0]       vec_o, nd_vec;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_has_addr(exc_has_addr), .exc_vaddr(exc_vaddr), .cur_pc(cur_pc),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .dbg_level(dbg_level),
        .ps_load(ps_load), .ps_load_val(ps_load_val), .ps_o(ps_o),
        .epc_o(epc_o), .depc_o(depc_o), .eps_o(eps_o), .excause_o(excause_o),
        .excvaddr_o(excvaddr_o), .dbgcause_o(dbgcause_o),
        .vec_valid_o(vec_valid_o), .vec_o(vec_o)
    );

    exc_entry_ctrl #(.HAS_DEPC(1'b0)) u_exc_entry_ctrl_nd (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_has_addr(exc_has_addr), .exc_vaddr(exc_vaddr), .cur_pc(cur_pc),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .dbg_level(dbg_level),
        .ps_load(ps_load), .ps_load_val(ps_load_val), .ps_o(nd_ps),
        .epc_o(nd_epc), .depc_o(nd_depc), .eps_o(nd_eps), .excause_o(nd_cause),
        .excvaddr_o(nd_vaddr), .dbgcause_o(nd_dcause),
        .vec_valid_o(nd_vld), .vec_o(nd_vec)
    );

    typedef struct packed {
        logic [7:0]       rq;
        logic             vld;
        logic [1:0]       vec;
        logic [7:0]       ps;
        logic [6:0][31:0] epc;
        logic [31:0]      depc;
        logic [5:0][7:0]  eps;
        logic [5:0]       cause;
        logic [31:0]      vaddr;
        logic [5:0]       dcause;
        logic [31:0]      nd_epc1;
    } exp_t;

    exp_t exp_q[$];

    logic [7:0]       m_ps;
    logic [6:0][31:0] m_epc;
    logic [31:0]      m_depc, m_vaddr, m_nd_epc1;
    logic [5:0][7:0]  m_eps;
    logic [5:0]       m_cause, m_dcause;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input string what, input int rq,
                       input logic [255:0] act, input logic [255:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    // Drive one cycle of stimulus, update the requirement model, queue expectation.
    task automatic apply(input int rq, input bit e, input logic [5:0] c,
                         input bit ha, input logic [31:0] va, input logic [31:0] pc,
                         input bit d, input logic [5:0] dc, input logic [3:0] lvl,
                         input bit ld, input logic [7:0] ldv);
        exp_t x;
        bit   dt;
        logic [1:0] v;
        @(negedge clk);
        exc_req = e; exc_cause = c; exc_has_addr = ha; exc_vaddr = va;
        cur_pc = pc; dbg_req = d; dbg_cause = dc; dbg_level = lvl;
        ps_load = ld; ps_load_val = ldv;
        dt = d && (lvl >= 4'd2) && (lvl <= 4'd7) && (m_ps[3:0] < lvl);
        v  = 2'd0;
        if (dt) begin
            m_dcause = dc;
            m_epc[lvl - 1] = pc;
            m_eps[lvl - 2] = m_ps;
            m_ps = {m_ps[7:5], 1'b1, lvl};
            v = 2'd3;
        end else if (e) begin
            if (ha) m_vaddr = va;
            if (m_ps[4]) begin
                m_depc = pc;
                v = 2'd2;
            end else begin
                m_epc[0] = pc;
                v = m_ps[5] ? 2'd0 : 2'd1;
            end
            m_nd_epc1 = pc;
            m_cause = c;
            m_ps[4] = 1'b1;
        end else if (ld) begin
            m_ps = ldv;
        end
        x.rq = 8'(rq); x.vld = dt || e; x.vec = v; x.ps = m_ps; x.epc = m_epc;
        x.depc = m_depc; x.eps = m_eps; x.cause = m_cause; x.vaddr = m_vaddr;
        x.dcause = m_dcause; x.nd_epc1 = m_nd_epc1;
        exp_q.push_back(x);
    endtask

    task automatic idle(input int rq);
        apply(rq, 0, 6'd0, 0, 32'd0, 32'd0, 0, 6'd0, 4'd0, 0, 8'd0);
    endtask

    // Monitor: compare both builds after each edge with a queued expectation.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            exp_t x;
            int   r;
            x = exp_q.pop_front();
            r = int'(x.rq);
            chk("vec_valid", r, 256'(vec_valid_o), 256'(x.vld));
            if (x.vld) chk("vector", r, 256'(vec_o), 256'(x.vec));
            chk("status", r, 256'(ps_o), 256'(x.ps));
            chk("epc", r, 256'(epc_o), 256'(x.epc));
            chk("depc", r, 256'(depc_o), 256'(x.depc));
            chk("eps", r, 256'(eps_o), 256'(x.eps));
            chk("excause", r, 256'(excause_o), 256'(x.cause));
            chk("excvaddr", r, 256'(excvaddr_o), 256'(x.vaddr));
            chk("dbgcause", r, 256'(dbgcause_o), 256'(x.dcause));
            chk("nodepc epc1", r, 256'(nd_epc[0]), 256'(x.nd_epc1));
            chk("nodepc depc", r, 256'(nd_depc), 256'd0);
            if (x.vld) chk("nodepc vector", r, 256'(nd_vec), 256'(x.vec));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        exc_req = 0; exc_cause = 0; exc_has_addr = 0; exc_vaddr = 0; cur_pc = 0;
        dbg_req = 0; dbg_cause = 0; dbg_level = 0; ps_load = 0; ps_load_val = 0;
        m_ps = 0; m_epc = '0; m_depc = 0; m_eps = '0; m_cause = 0; m_dcause = 0;
        m_vaddr = 0; m_nd_epc1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("reset status", 1, 256'(ps_o), 256'd0);
        chk("reset epc", 1, 256'(epc_o), 256'd0);
        chk("reset cause", 1, 256'(excause_o), 256'd0);
        chk("reset valid", 1, 256'(vec_valid_o), 256'd0);
        chk("reset eps", 1, 256'(eps_o), 256'd0);
        rst = 1'b0;

        // R2 kernel vector, R6 address captured, R5 cause and EXCM
        apply(2, 1, 6'd5, 1, 32'hDEAD_0000, 32'h0000_1000, 0, 6'd0, 4'd0, 0, 8'd0);
        idle(9);
        // R3 double path to DEPC; R4 on the other build; R6 no address keeps old
        apply(3, 1, 6'd9, 0, 32'h1111_1111, 32'h0000_2000, 0, 6'd0, 4'd0, 0, 8'd0);
        idle(9);
        // R11 status load, then R2 user vector
        apply(11, 0, 6'd0, 0, 32'd0, 32'd0, 0, 6'd0, 4'd0, 1, 8'h20);
        apply(2, 1, 6'd3, 1, 32'h0000_BEEF, 32'h0000_3000, 0, 6'd0, 4'd0, 0, 8'd0);
        // R9 back-to-back second request, EXCM set: R4 / R3
        apply(4, 1, 6'd7, 0, 32'd0, 32'h0000_3004, 0, 6'd0, 4'd0, 0, 8'd0);
        idle(9);
        // R7 level equal to debug level is ignored
        apply(11, 0, 6'd0, 0, 32'd0, 32'd0, 0, 6'd0, 4'd0, 1, 8'h23);
        apply(7, 0, 6'd0, 0, 32'd0, 32'h0000_4000, 1, 6'd2, 4'd3, 0, 8'd0);
        idle(7);
        // R8 debug taken at level 5
        apply(8, 0, 6'd0, 0, 32'd0, 32'h0000_5000, 1, 6'd4, 4'd5, 0, 8'd0);
        idle(9);
        // R10 debug and general together: debug wins
        apply(10, 1, 6'd33, 1, 32'hAAAA_AAAA, 32'h0000_6000, 1, 6'd8, 4'd6, 0, 8'd0);
        // R8 highest level boundary
        apply(8, 0, 6'd0, 0, 32'd0, 32'h0000_7000, 1, 6'd16, 4'd7, 0, 8'd0);
        idle(9);
        // R7 out-of-range levels ignored
        apply(11, 0, 6'd0, 0, 32'd0, 32'd0, 0, 6'd0, 4'd0, 1, 8'h00);
        apply(7, 0, 6'd0, 0, 32'd0, 32'h0000_8000, 1, 6'd1, 4'd1, 0, 8'd0);
        apply(7, 0, 6'd0, 0, 32'd0, 32'h0000_8004, 1, 6'd1, 4'd8, 0, 8'd0);
        apply(7, 0, 6'd0, 0, 32'd0, 32'h0000_8008, 1, 6'd1, 4'd0, 0, 8'd0);
        // R11 status load loses to a general exception
        apply(11, 1, 6'd12, 0, 32'd0, 32'h0000_9000, 0, 6'd0, 4'd0, 1, 8'h2F);
        idle(9);
        // R8 debug level 2 lowest boundary
        apply(11, 0, 6'd0, 0, 32'd0, 32'd0, 0, 6'd0, 4'd0, 1, 8'h21);
        apply(8, 0, 6'd0, 0, 32'd0, 32'h0000_A000, 1, 6'd5, 4'd2, 0, 8'd0);
        idle(9);

        @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule